// File: doc/BRIEF.md
# External Bus Access Stretch Controller

This block lengthens accesses to an external memory bus by a programmable number of clock cycles. A small configuration register holds a three-bit stretch code and a wait-enable bit. When the CPU side raises a request that targets external space while the chip runs in one of the two expanded operating modes, the block holds the access open for the programmed number of extra cycles. It then acknowledges with a single-cycle pulse.

When the wait enable is set, the programmed count becomes a minimum. After it expires, the access stays open for as long as the active-low external wait pin is held low. The pin passes through a two-stage synchronizer first. In every other operating mode, and for accesses that miss external space, the access completes in the base time and the wait pin has no effect.

The configuration register can be read and written at any time. In emulation expanded mode, writes are also forwarded to the external bus, and reads return the value the external bus supplies.

Top module: `ext_stretch_ctrl`

## Requirements
- R1: After reset the configuration reads 0x07 (wait enable 0, stretch code 111), `ack_o` is low and `bus_cyc_o` is low.
- R2: Outside emulation mode (mode 01 normal expanded, 00 single chip, 11 special), a write stores data bit 7 as wait enable and bits 2:0 as stretch code. Reads return {enable, 4'b0000, code}, bits 6:3 always zero, and `ebus_cfg_wr_o` stays low.
- R3: In emulation expanded mode (mode 10), a read returns `ebus_cfg_rdata_i`. A write drives `ebus_cfg_wr_o` high with `ebus_cfg_wdata_o` equal to the write data, and also updates the internal register.
- R4: With wait enable 0, in mode 01 or 10, an external access (ext_hit 1) whose request is sampled at edge k raises `ack_o` after edge k+2+code, i.e. code+1 extra cycles over the unstretched case.
- R5: In modes 00 and 11 an external access acknowledges after edge k+1 regardless of code and wait enable, and a low wait pin is ignored.
- R6: An access with ext_hit 0 acknowledges after edge k+1 in any mode.
- R7: With wait enable 1 in an expanded mode and the wait pin high, codes 000 and 001 both give 2 stretch cycles, and codes 010 to 111 give code+1.
- R8: With wait enable 1 in an expanded mode and the wait pin low, the access ends only after the release has passed the two synchronizer flops. A release between edges P and P+1 gives ack after edge P+3, if the minimum has already expired.
- R9: `ack_o` is high for exactly one cycle per access, and requests raised while an access is in progress are ignored.
- R10: Rewriting the configuration during an access does not change that access's length. The new code applies from the next access.
- R11: `bus_cyc_o` is high from the cycle after the request is accepted until the ack cycle, for external-hit accesses only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Operating mode: 00 single chip, 01 normal expanded, 10 emulation expanded, 11 special |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration read data |
| ebus_cfg_rdata_i | input | 8 | Configuration value sampled from the external bus (emulation) |
| ebus_cfg_wr_o | output | 1 | Forwarded write strobe to the external bus (emulation) |
| ebus_cfg_wdata_o | output | 8 | Forwarded write data |
| req_i | input | 1 | CPU access request |
| ext_hit_i | input | 1 | Request targets external address space |
| ack_o | output | 1 | One-cycle access completion pulse |
| ewait_n_i | input | 1 | Active-low external wait pin, asynchronous |
| bus_cyc_o | output | 1 | External access in progress |

## Verification
The hardest case to reach is an access held by the wait pin after its minimum has run out, where the ack edge depends on when the release crosses the synchronizer. The bench drives the pin low several cycles before the request, so the synchronized value is already active at acceptance. It then releases the pin at a chosen edge count and expects ack exactly three edges later. A second hard case is a configuration rewrite in mid-access. The bench issues that write while the counter is running and checks that the current access keeps its length and the next access uses the new code.

// File: rtl/ext_stretch_pkg.sv
package ext_stretch_pkg;
  localparam int STR_W = 3;
  localparam int CNT_W = STR_W + 1;
  localparam int CFG_W = 8;
  localparam int WEN_BIT = 7;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_NEXP   = 2'b01,
    MODE_EMU    = 2'b10,
    MODE_SPEC   = 2'b11
  } op_mode_e;

  function automatic logic is_expanded(input logic [1:0] m);
    return (m == MODE_NEXP) || (m == MODE_EMU);
  endfunction

  // Minimum stretch count for a code; wait enable lifts the floor to two.
  function automatic logic [CNT_W-1:0] min_stretch(input logic [STR_W-1:0] code,
                                                    input logic wen);
    logic [CNT_W-1:0] base;
    base = {1'b0, code} + CNT_W'(1);
    if (wen && (base < CNT_W'(2))) return CNT_W'(2);
    return base;
  endfunction
endpackage

// File: rtl/ext_stretch_cfg.sv
module ext_stretch_cfg
  import ext_stretch_pkg::*;
#(
  parameter logic [STR_W-1:0] RST_CODE = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic [CFG_W-1:0] ebus_rdata_i,
  output logic [CFG_W-1:0] rdata_o,
  output logic             ebus_wr_o,
  output logic [CFG_W-1:0] ebus_wdata_o,
  output logic [STR_W-1:0] code_o,
  output logic             wen_o
);
  logic [STR_W-1:0] code_q, code_d;
  logic             wen_q, wen_d;
  logic             emu;
  logic             reg_en;

  assign emu    = (mode_i == MODE_EMU);
  assign reg_en = wr_i;

  always_comb begin
    code_d = code_q;
    wen_d  = wen_q;
    if (reg_en) begin
      code_d = wdata_i[STR_W-1:0];
      wen_d  = wdata_i[WEN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= RST_CODE;
      wen_q  <= 1'b0;
    end else if (reg_en) begin
      code_q <= code_d;
      wen_q  <= wen_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (emu) begin
      rdata_o = ebus_rdata_i;
    end else begin
      rdata_o[STR_W-1:0] = code_q;
      rdata_o[WEN_BIT]   = wen_q;
    end
  end

  assign ebus_wr_o    = wr_i && emu;
  assign ebus_wdata_o = wdata_i;
  assign code_o       = code_q;
  assign wen_o        = wen_q;

  // R2
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !emu |-> (rdata_o[WEN_BIT-1:STR_W] == '0));
  // R3
  fwd_only_emu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ebus_wr_o |-> (mode_i == MODE_EMU) && wr_i);
endmodule

// File: rtl/ext_stretch_wsync.sv
module ext_stretch_wsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n_i,
  output logic wait_act_o
);
  logic [STAGES-1:0] sync_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b1;
        else if (i == 0) sync_q[i] <= pin_n_i;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign wait_act_o = ~sync_q[STAGES-1];
endmodule

// File: rtl/ext_stretch_seq.sv
module ext_stretch_seq
  import ext_stretch_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             ext_hit_i,
  input  logic             expanded_i,
  input  logic [STR_W-1:0] code_i,
  input  logic             wen_i,
  input  logic             wait_act_i,
  output logic             ack_o,
  output logic             ext_cyc_o
);
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hold_q, hold_d;
  logic             ext_q, ext_d;
  logic             ack_q, ack_d;
  logic             stretch;
  logic             done;

  assign stretch = ext_hit_i && expanded_i;
  assign done    = busy_q && (cnt_q == '0) && !(hold_q && wait_act_i);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    hold_d = hold_q;
    ext_d  = ext_q;
    ack_d  = 1'b0;
    if (!busy_q) begin
      if (req_i) begin
        busy_d = 1'b1;
        ext_d  = ext_hit_i;
        hold_d = stretch && wen_i;
        cnt_d  = stretch ? min_stretch(code_i, wen_i) : '0;
      end
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end else if (done) begin
      busy_d = 1'b0;
      ext_d  = 1'b0;
      hold_d = 1'b0;
      ack_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      hold_q <= 1'b0;
      ext_q  <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
      ext_q  <= ext_d;
      ack_q  <= ack_d;
    end
  end

  assign ack_o     = ack_q;
  assign ext_cyc_o = busy_q && ext_q;

  // R9
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);
  // R9
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> !busy_q);
  // R4
  no_early_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> busy_q && !ack_q);
  // R8
  hold_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q == '0 && hold_q && wait_act_i) |=> busy_q);
  // R10
  count_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/ext_stretch_ctrl.sv
module ext_stretch_ctrl
  import ext_stretch_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       cfg_wr_i,
  input  logic [7:0] cfg_wdata_i,
  output logic [7:0] cfg_rdata_o,
  input  logic [7:0] ebus_cfg_rdata_i,
  output logic       ebus_cfg_wr_o,
  output logic [7:0] ebus_cfg_wdata_o,
  input  logic       req_i,
  input  logic       ext_hit_i,
  output logic       ack_o,
  input  logic       ewait_n_i,
  output logic       bus_cyc_o
);
  logic [STR_W-1:0] code;
  logic             wen;
  logic             wait_act;

  ext_stretch_cfg u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_i),
    .wr_i         (cfg_wr_i),
    .wdata_i      (cfg_wdata_i),
    .ebus_rdata_i (ebus_cfg_rdata_i),
    .rdata_o      (cfg_rdata_o),
    .ebus_wr_o    (ebus_cfg_wr_o),
    .ebus_wdata_o (ebus_cfg_wdata_o),
    .code_o       (code),
    .wen_o        (wen)
  );

  ext_stretch_wsync #(.STAGES(SYNC_STAGES)) u_wsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_n_i    (ewait_n_i),
    .wait_act_o (wait_act)
  );

  ext_stretch_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .ext_hit_i  (ext_hit_i),
    .expanded_i (is_expanded(mode_i)),
    .code_i     (code),
    .wen_i      (wen),
    .wait_act_i (wait_act),
    .ack_o      (ack_o),
    .ext_cyc_o  (bus_cyc_o)
  );

  // R11
  cyc_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> !bus_cyc_o);
endmodule

// File: tb/ext_stretch_ctrl_tb.sv
module ext_stretch_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_i = 2'b01;
  logic       cfg_wr_i = 1'b0;
  logic [7:0] cfg_wdata_i = '0;
  logic [7:0] cfg_rdata_o;
  logic [7:0] ebus_cfg_rdata_i = 8'h00;
  logic       ebus_cfg_wr_o;
  logic [7:0] ebus_cfg_wdata_o;
  logic       req_i = 1'b0;
  logic       ext_hit_i = 1'b1;
  logic       ack_o;
  logic       ewait_n_i = 1'b1;
  logic       bus_cyc_o;

  int errs = 0;
  int checks = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  ext_stretch_ctrl u_dut (.*);

  // {mode[12:11], ext[10], wen[9], code[8:6], latency[5:0]}
  localparam int NV = 11;
  localparam logic [12:0] VEC [NV] = '{
    {2'b01, 1'b1, 1'b0, 3'd0, 6'd3},
    {2'b01, 1'b1, 1'b0, 3'd3, 6'd6},
    {2'b01, 1'b1, 1'b0, 3'd7, 6'd10},
    {2'b10, 1'b1, 1'b0, 3'd5, 6'd8},
    {2'b00, 1'b1, 1'b0, 3'd7, 6'd2},
    {2'b11, 1'b1, 1'b1, 3'd7, 6'd2},
    {2'b01, 1'b0, 1'b0, 3'd7, 6'd2},
    {2'b01, 1'b1, 1'b1, 3'd0, 6'd4},
    {2'b01, 1'b1, 1'b1, 3'd1, 6'd4},
    {2'b01, 1'b1, 1'b1, 3'd2, 6'd5},
    {2'b10, 1'b1, 1'b1, 3'd6, 6'd9}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] d);
    @(negedge clk);
    cfg_wr_i = 1'b1;
    cfg_wdata_i = d;
    @(negedge clk);
    cfg_wr_i = 1'b0;
  endtask

  // Pulses req for one cycle; counts edges until ack is seen and bus_cyc samples.
  task automatic access(input int rel_at, output int lat, output int cyc, output int acks);
    @(negedge clk);
    req_i = 1'b1;
    lat = 0; cyc = 0; acks = 0;
    for (int n = 1; n < 60; n++) begin
      @(negedge clk);
      req_i = 1'b0;
      if (n == rel_at) ewait_n_i = 1'b1;
      if (bus_cyc_o) cyc++;
      if (ack_o) begin
        acks++;
        if (lat == 0) lat = n;
      end
    end
  endtask

  initial begin
    #2_000_000;
    if (!done_flag) begin
      errs++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int lat, cyc, acks;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cfg", int'(cfg_rdata_o), 8'h07);
    chk("R1 ack", int'(ack_o), 0);
    chk("R1 bus_cyc", int'(bus_cyc_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 layout and no forwarding outside emulation
    mode_i = 2'b01;
    @(negedge clk);
    cfg_wr_i = 1'b1; cfg_wdata_i = 8'hFF;
    #1 chk("R2 no fwd", int'(ebus_cfg_wr_o), 0);
    @(negedge clk);
    cfg_wr_i = 1'b0;
    chk("R2 read FF", int'(cfg_rdata_o), 8'h87);
    cfg_write(8'h7A);
    chk("R2 read 7A", int'(cfg_rdata_o), 8'h02);

    // R3 emulation read/forward
    mode_i = 2'b10;
    ebus_cfg_rdata_i = 8'h5C;
    @(negedge clk);
    chk("R3 read ebus", int'(cfg_rdata_o), 8'h5C);
    cfg_wr_i = 1'b1; cfg_wdata_i = 8'h85;
    #1 chk("R3 fwd wr", int'(ebus_cfg_wr_o), 1);
    chk("R3 fwd data", int'(ebus_cfg_wdata_o), 8'h85);
    @(negedge clk);
    cfg_wr_i = 1'b0;
    mode_i = 2'b01;
    #1 chk("R3 internal", int'(cfg_rdata_o), 8'h85);

    // Table: R4 R5 R6 R7 R11
    for (int i = 0; i < NV; i++) begin
      mode_i = VEC[i][12:11];
      ext_hit_i = VEC[i][10];
      cfg_write({VEC[i][9], 4'b0, VEC[i][8:6]});
      access(-1, lat, cyc, acks);
      chk($sformatf("R4/R5/R6/R7 vec%0d latency", i), lat, int'(VEC[i][5:0]));
      chk($sformatf("R11 vec%0d bus_cyc", i), cyc, VEC[i][10] ? int'(VEC[i][5:0]) - 1 : 0);
      chk($sformatf("R9 vec%0d acks", i), acks, 1);
    end
    ext_hit_i = 1'b1;

    // R8 wait pin held past minimum
    mode_i = 2'b01;
    cfg_write(8'h80);
    ewait_n_i = 1'b0;
    repeat (4) @(negedge clk);
    access(10, lat, cyc, acks);
    chk("R8 wait release", lat, 13);
    // R8 release before minimum expires: minimum governs
    ewait_n_i = 1'b0;
    cfg_write(8'h86);
    repeat (4) @(negedge clk);
    access(1, lat, cyc, acks);
    chk("R8 early release", lat, 9);

    // R5 wait ignored in single-chip mode
    mode_i = 2'b00;
    ewait_n_i = 1'b0;
    repeat (4) @(negedge clk);
    access(-1, lat, cyc, acks);
    chk("R5 wait ignored", lat, 2);
    ewait_n_i = 1'b1;
    mode_i = 2'b01;

    // R9 requests during access ignored
    cfg_write(8'h07);
    @(negedge clk);
    req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    acks = 0;
    for (int n = 0; n < 25; n++) begin
      if (n == 3 || n == 6) req_i = 1'b1; else req_i = 1'b0;
      @(negedge clk);
      if (ack_o) acks++;
    end
    req_i = 1'b0;
    chk("R9 single ack", acks, 1);

    // R10 rewrite mid-access
    @(negedge clk);
    req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    cfg_wr_i = 1'b1; cfg_wdata_i = 8'h00;
    lat = 0;
    for (int n = 2; n < 30; n++) begin
      @(negedge clk);
      cfg_wr_i = 1'b0;
      if (ack_o && lat == 0) lat = n;
    end
    chk("R10 in-flight", lat, 10);
    access(-1, lat, cyc, acks);
    chk("R10 next access", lat, 3);

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule